// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and control flags of an 8-bit processor core in one byte. Five arithmetic flags (half carry, two's-complement overflow, negative, zero, carry) are loaded from the ALU's result flags through a per-flag write mask. An operation therefore changes only the flags it defines, and all other flags keep their values. The sign flag is not loaded from any source. It is always recomputed as negative xor overflow from the flag values being registered, so it stays consistent after ALU updates and after software writes.

The interrupt-enable flag is cleared by hardware when an interrupt is acknowledged. It is set again by the return-from-interrupt strobe, and dedicated set and clear strobes also control it. When it is low, the interrupt-permit output is low, whatever the individual enables are. A single-bit transfer flag receives one selected bit of an operand byte (a bit-store operation). Its value is always presented on a separate output so the datapath can insert it into a register bit (a bit-load operation). Software may write the whole byte.

All updates take effect at the clock edge that ends the cycle in which they are requested. The block does not save or restore the flags on interrupt entry or exit.

Top module: `proc_status_reg`

## Requirements
- R1: While the reset input is low, and after it is released, `status_o` reads 8'h00 until the first update.
- R2: The bit layout of `status_o` is: enable = bit 7, transfer = bit 6, H = bit 5, S = bit 4, V = bit 3, N = bit 2, Z = bit 1, C = bit 0. When `alu_mask_i` bit k is 1 for k in {5,3,2,1,0}, flag k takes `alu_flags_i` bit k at the next edge. When that mask bit is 0, the flag keeps its value. Bits 7, 6 and 4 of `alu_mask_i` and `alu_flags_i` have no effect.
- R3: After every edge, `status_o[4]` equals `status_o[2]` xor `status_o[3]`. This includes software writes that carry a different bit 4.
- R4: When `int_ack_i` is high, bit 7 is 0 after the edge. This holds even if return, set, clear or a software write is requested in the same cycle.
- R5: When `int_ret_i` is high without `int_ack_i`, bit 7 is 1 after the edge, even if `ien_clr_i` is also high.
- R6: Without acknowledge or return, `ien_clr_i` clears bit 7 and takes priority over `ien_set_i`. `ien_set_i` alone sets bit 7. Either strobe takes priority over a software write of bit 7.
- R7: When `sw_wr_i` is high, bits 5, 3, 2, 1 and 0 take `sw_data_i` at the next edge, overriding ALU updates. Bit 7 takes `sw_data_i[7]` unless an acknowledge, return or enable strobe is active. Bit 6 takes `sw_data_i[6]` unless a bit-store is active.
- R8: When `bst_en_i` is high, bit 6 becomes `bst_operand_i[bst_index_i]` at the next edge. This takes priority over a software write of bit 6.
- R9: `bld_bit_o` always equals `status_o[6]`.
- R10: `irq_permit_o` is high exactly when `status_o[7]` is 1 and some bit of `irq_req_i & irq_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_flags_i | input | 8 | ALU result flags in status bit positions |
| alu_mask_i | input | 8 | Per-flag write mask for the ALU flags |
| int_ack_i | input | 1 | Interrupt acknowledge; clears the enable flag |
| int_ret_i | input | 1 | Return from interrupt; sets the enable flag |
| ien_clr_i | input | 1 | Clear-enable strobe |
| ien_set_i | input | 1 | Set-enable strobe |
| bst_en_i | input | 1 | Bit-store request |
| bst_operand_i | input | 8 | Operand byte for bit-store |
| bst_index_i | input | 3 | Index of the bit to store |
| sw_wr_i | input | 1 | Full-byte software write strobe |
| sw_data_i | input | 8 | Software write data |
| irq_req_i | input | NIRQ | Interrupt request lines |
| irq_en_i | input | NIRQ | Individual interrupt enables |
| status_o | output | 8 | Status byte |
| bld_bit_o | output | 1 | Transfer flag, for bit-load into a register |
| irq_permit_o | output | 1 | An enabled request is allowed to interrupt |

## Verification
Several pairs of functions can fall in the same cycle. The bench drives them together at one falling edge: acknowledge with return, set and a software write; return with clear; clear with set; bit-store with a software write that carries the opposite transfer value; and a software write with a full ALU mask. Each result is judged against a priority model in the bench that resolves every bit independently. The sign bit is judged against the freshly registered N and V, including software bytes whose bit 4 contradicts them.

// File: rtl/stflag_pkg.sv
package stflag_pkg;
  localparam int FLAG_W = 8;
  localparam int IDX_W  = $clog2(FLAG_W);
  // flag positions inside the status byte
  localparam int B_C  = 0;
  localparam int B_Z  = 1;
  localparam int B_N  = 2;
  localparam int B_V  = 3;
  localparam int B_S  = 4;
  localparam int B_H  = 5;
  localparam int B_T  = 6;
  localparam int B_IE = 7;
  localparam int AR_W = 5; // arithmetic group {H,V,N,Z,C}

  function automatic logic sign_of(input logic n, input logic v);
    return n ^ v;
  endfunction

  function automatic logic pick_bit(input logic [FLAG_W-1:0] b,
                                    input logic [IDX_W-1:0] idx);
    return b[idx];
  endfunction

  function automatic logic [AR_W-1:0] arith_of(input logic [FLAG_W-1:0] b);
    return {b[B_H], b[B_V], b[B_N], b[B_Z], b[B_C]};
  endfunction

  function automatic logic [AR_W-1:0] merge(input logic [AR_W-1:0] old_v,
                                            input logic [AR_W-1:0] new_v,
                                            input logic [AR_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/stflag_ien_ctrl.sv
module stflag_ien_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic ret_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic sw_wr_i,
  input  logic sw_val_i,
  output logic ien_q
);
  logic ev_force_clr;
  logic ev_force_set;
  logic ien_d;

  assign ev_force_clr = ack_i | (!ret_i & clr_i);
  assign ev_force_set = !ack_i & (ret_i | (!clr_i & set_i));

  always_comb begin
    if (ev_force_clr)      ien_d = 1'b0;
    else if (ev_force_set) ien_d = 1'b1;
    else if (sw_wr_i)      ien_d = sw_val_i;
    else                   ien_d = ien_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ien_q <= 1'b0;
    else        ien_q <= ien_d;

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !ien_q);
  a_r5_ret_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !ack_i) |=> ien_q);
  a_r6_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !ack_i && !ret_i) |=> !ien_q);
  a_r6_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !ack_i && !ret_i) |=> ien_q);
endmodule

// File: rtl/stflag_tbit.sv
module stflag_tbit
  import stflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bst_en_i,
  input  logic [FLAG_W-1:0] operand_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic              sw_wr_i,
  input  logic              sw_val_i,
  output logic              t_q
);
  logic ev_store;
  logic t_d;

  assign ev_store = bst_en_i;

  always_comb begin
    if (ev_store)     t_d = pick_bit(operand_i, index_i);
    else if (sw_wr_i) t_d = sw_val_i;
    else              t_d = t_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) t_q <= 1'b0;
    else        t_q <= t_d;

  a_r8_store_copies: assert property (@(posedge clk) disable iff (!rst_n)
    bst_en_i |=> t_q == $past(operand_i[index_i]));
  a_r7_sw_loads_t: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && !bst_en_i) |=> t_q == $past(sw_val_i));
  a_r8_t_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_i && !bst_en_i) |=> $stable(t_q));
endmodule

// File: rtl/stflag_arith.sv
module stflag_arith
  import stflag_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AR_W-1:0] alu_val_i,
  input  logic [AR_W-1:0] alu_mask_i,
  input  logic            sw_wr_i,
  input  logic [AR_W-1:0] sw_val_i,
  output logic [AR_W-1:0] ar_q,   // {H,V,N,Z,C}
  output logic            s_q
);
  logic [AR_W-1:0] ar_d;

  always_comb begin
    if (sw_wr_i) ar_d = sw_val_i;
    else         ar_d = merge(ar_q, alu_val_i, alu_mask_i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ar_q <= '0;
      s_q  <= 1'b0;
    end else begin
      ar_q <= ar_d;
      s_q  <= sign_of(ar_d[2], ar_d[3]);
    end

  a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_i |=> ((ar_q ^ $past(ar_q)) & ~$past(alu_mask_i)) == '0);
  a_r2_masked_load: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_i |=> (ar_q & $past(alu_mask_i)) == ($past(alu_val_i) & $past(alu_mask_i)));
  a_r7_sw_over_alu: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> ar_q == $past(sw_val_i));
endmodule

// File: rtl/proc_status_reg.sv
module proc_status_reg
  import stflag_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] alu_flags_i,
  input  logic [FLAG_W-1:0] alu_mask_i,
  input  logic              int_ack_i,
  input  logic              int_ret_i,
  input  logic              ien_clr_i,
  input  logic              ien_set_i,
  input  logic              bst_en_i,
  input  logic [FLAG_W-1:0] bst_operand_i,
  input  logic [IDX_W-1:0]  bst_index_i,
  input  logic              sw_wr_i,
  input  logic [FLAG_W-1:0] sw_data_i,
  input  logic [NIRQ-1:0]   irq_req_i,
  input  logic [NIRQ-1:0]   irq_en_i,
  output logic [FLAG_W-1:0] status_o,
  output logic              bld_bit_o,
  output logic              irq_permit_o
);
  logic            ien_q;
  logic            t_q;
  logic [AR_W-1:0] ar_q;
  logic            s_q;
  logic            ev_any_enabled;
  logic [6:0]      unused_bits;

  assign unused_bits = {alu_flags_i[B_IE], alu_flags_i[B_T], alu_flags_i[B_S],
                        alu_mask_i[B_IE], alu_mask_i[B_T], alu_mask_i[B_S],
                        sw_data_i[B_S]};

  stflag_ien_ctrl u_ien (
    .clk(clk), .rst_n(rst_n),
    .ack_i(int_ack_i), .ret_i(int_ret_i),
    .clr_i(ien_clr_i), .set_i(ien_set_i),
    .sw_wr_i(sw_wr_i), .sw_val_i(sw_data_i[B_IE]),
    .ien_q(ien_q)
  );

  stflag_tbit u_tbit (
    .clk(clk), .rst_n(rst_n),
    .bst_en_i(bst_en_i), .operand_i(bst_operand_i), .index_i(bst_index_i),
    .sw_wr_i(sw_wr_i), .sw_val_i(sw_data_i[B_T]),
    .t_q(t_q)
  );

  stflag_arith u_arith (
    .clk(clk), .rst_n(rst_n),
    .alu_val_i(arith_of(alu_flags_i)), .alu_mask_i(arith_of(alu_mask_i)),
    .sw_wr_i(sw_wr_i), .sw_val_i(arith_of(sw_data_i)),
    .ar_q(ar_q), .s_q(s_q)
  );

  assign status_o = {ien_q, t_q, ar_q[4], s_q, ar_q[3:0]};
  assign bld_bit_o = t_q;
  assign ev_any_enabled = |(irq_req_i & irq_en_i);
  assign irq_permit_o = ien_q & ev_any_enabled;

  a_r3_sign_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[B_S] == (status_o[B_N] ^ status_o[B_V]));
  a_r10_no_permit_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[B_IE] |-> !irq_permit_o);
endmodule

// File: tb/test_proc_status_reg.sv
`timescale 1ns/1ps
module test_proc_status_reg;
  localparam int NIRQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] alu_flags_i = '0, alu_mask_i = '0;
  logic int_ack_i = 0, int_ret_i = 0, ien_clr_i = 0, ien_set_i = 0;
  logic bst_en_i = 0;
  logic [7:0] bst_operand_i = '0;
  logic [2:0] bst_index_i = '0;
  logic sw_wr_i = 0;
  logic [7:0] sw_data_i = '0;
  logic [NIRQ-1:0] irq_req_i = '0, irq_en_i = '0;
  logic [7:0] status_o;
  logic bld_bit_o, irq_permit_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_st = '0;

  typedef struct { logic [7:0] st; string tag; } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  proc_status_reg #(.NIRQ(NIRQ)) i_proc_status_reg (
    .clk(clk), .rst_n(rst_n), .alu_flags_i(alu_flags_i), .alu_mask_i(alu_mask_i),
    .int_ack_i(int_ack_i), .int_ret_i(int_ret_i), .ien_clr_i(ien_clr_i),
    .ien_set_i(ien_set_i), .bst_en_i(bst_en_i), .bst_operand_i(bst_operand_i),
    .bst_index_i(bst_index_i), .sw_wr_i(sw_wr_i), .sw_data_i(sw_data_i),
    .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .status_o(status_o),
    .bld_bit_o(bld_bit_o), .irq_permit_o(irq_permit_o)
  );

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte after each edge that has one queued
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check8(it.tag, status_o, it.st);
      check8("R9 bld", {7'd0, bld_bit_o}, {7'd0, it.st[6]});
    end
  end

  // driver: drive one cycle, compute the expected byte, queue it
  task automatic cyc(string tag, logic ack, logic ret, logic clr, logic set,
                     logic bst, logic [7:0] op, logic [2:0] idx,
                     logic sw, logic [7:0] swd, logic [7:0] alu, logic [7:0] msk);
    logic [7:0] n;
    logic [7:0] am;
    item_t it;
    @(negedge clk);
    int_ack_i = ack; int_ret_i = ret; ien_clr_i = clr; ien_set_i = set;
    bst_en_i = bst; bst_operand_i = op; bst_index_i = idx;
    sw_wr_i = sw; sw_data_i = swd; alu_flags_i = alu; alu_mask_i = msk;
    n = exp_st;
    if (ack)      n[7] = 1'b0;
    else if (ret) n[7] = 1'b1;
    else if (clr) n[7] = 1'b0;
    else if (set) n[7] = 1'b1;
    else if (sw)  n[7] = swd[7];
    if (bst)      n[6] = op[idx];
    else if (sw)  n[6] = swd[6];
    am = msk & 8'b0010_1111;
    if (sw) n = (n & 8'b1100_0000) | (swd & 8'b0010_1111);
    else    n = (n & ~am) | (alu & am);
    n[4] = n[2] ^ n[3];
    exp_st = n;
    it.st = n; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle();
    cyc("idle", 0,0,0,0, 0,8'h00,3'd0, 0,8'h00, 8'h00,8'h00);
  endtask

  task automatic chk_permit(string tag, logic [NIRQ-1:0] req, logic [NIRQ-1:0] en);
    @(negedge clk);
    irq_req_i = req; irq_en_i = en;
    #1;
    check8(tag, {7'd0, irq_permit_o}, {7'd0, exp_st[7] & (|(req & en))});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check8("R1 during reset", status_o, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    #1 check8("R1 after release", status_o, 8'h00);
    // R2 ALU masked updates
    cyc("R2 full mask", 0,0,0,0, 0,0,0, 0,0, 8'b0010_1111, 8'b1111_1111);
    cyc("R2 partial mask", 0,0,0,0, 0,0,0, 0,0, 8'b0000_0000, 8'b0000_0101);
    cyc("R2 ignored bits", 0,0,0,0, 0,0,0, 0,0, 8'b1101_0000, 8'b1101_0000);
    cyc("R2 V only", 0,0,0,0, 0,0,0, 0,0, 8'b0000_0000, 8'b0000_1000);
    // R3 sign after software write contradicting bit 4
    cyc("R3 sw N=1 V=0 S=0", 0,0,0,0, 0,0,0, 1,8'b0000_0100, 8'h00,8'h00);
    cyc("R3 sw N=1 V=1 S=1", 0,0,0,0, 0,0,0, 1,8'b0001_1100, 8'h00,8'h00);
    // R6 set / clear
    cyc("R6 set alone", 0,0,0,1, 0,0,0, 0,0, 0,0);
    cyc("R6 clr beats set", 0,0,1,1, 0,0,0, 0,0, 0,0);
    cyc("R6 set beats sw", 0,0,0,1, 0,0,0, 1,8'h00, 0,0);
    // R4 ack beats everything
    cyc("R4 ack with ret/set/sw", 1,1,0,1, 0,0,0, 1,8'hFF, 0,0);
    // R5 ret beats clr
    cyc("R5 ret with clr", 0,1,1,0, 0,0,0, 0,0, 0,0);
    cyc("R6 clr beats sw", 0,0,1,0, 0,0,0, 1,8'h80, 0,0);
    // R7 software write over ALU
    cyc("R7 sw over alu", 0,0,0,0, 0,0,0, 1,8'b1100_1010, 8'b0010_0101, 8'hFF);
    cyc("R7 sw clears", 0,0,0,0, 0,0,0, 1,8'h00, 8'h00, 8'h00);
    // R8 bit store
    cyc("R8 bst idx5", 0,0,0,0, 1,8'b0010_0000,3'd5, 0,0, 0,0);
    cyc("R8 bst idx0 zero", 0,0,0,0, 1,8'b1111_1110,3'd0, 0,0, 0,0);
    cyc("R8 bst idx7", 0,0,0,0, 1,8'b1000_0000,3'd7, 0,0, 0,0);
    cyc("R8 bst beats sw", 0,0,0,0, 1,8'b0000_0000,3'd3, 1,8'b0100_0000, 0,0);
    cyc("R7 sw loads T", 0,0,0,0, 0,0,0, 1,8'b0100_0000, 0,0);
    idle();
    // R10 permit
    cyc("R6 set for R10", 0,0,0,1, 0,0,0, 0,0, 0,0);
    idle();
    chk_permit("R10 on, req&en", 4'b0010, 4'b0010);
    chk_permit("R10 on, no enable", 4'b0010, 4'b0100);
    cyc("R4 ack for R10", 1,0,0,0, 0,0,0, 0,0, 0,0);
    idle();
    chk_permit("R10 off, req&en", 4'b1111, 4'b1111);
    repeat (3) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule